// File: doc/BRIEF.md
# Binarized Fully Connected Layer Engine

This block evaluates one fully connected layer of a binarized neural network. The layer has N binary inputs and N binary outputs; its N×N binary weights sit in an external on-chip RAM. The RAM is read one N-bit word per cycle. A start pulse captures the input vector and a base address. The engine then streams N consecutive weight words. Each word is compared bit-for-bit, using XNOR, with a copy of the input that is rotated left by one bit after every word. The agreements are accumulated in one counter per output neuron. When all N words have been consumed, each output bit is decided by majority vote and the engine raises `done`.

The engine holds no weights of its own. A layer sequencer can reuse it for successive layers by presenting a new input vector and a new weight base address with each start. Because the input rotates, weight word k must hold, in bit i, the weight connecting neuron i to input (i − k) mod N. After N words, every neuron has then met every input exactly once.

Top module: `bnn_layer_engine`

## Requirements
- R1: While and after reset, `busy`, `done` and `w_rd_en` are 0 and `out_vec` is all zeros.
- R2: A start accepted while idle causes N reads. The first read is issued with `w_addr` equal to the sampled `w_base`, in the cycle after the start edge. Each later read is issued in the following cycle at the previous address plus one, modulo 2^AW. `w_rd_en` is high only for these N cycles, and only while `busy`.
- R3: The RAM returns `w_data` one clock after the address is issued. Word k (0-based) bit i is combined with input bit (i − k) mod N, so that neuron i sees each input exactly once. Bit value 1 stands for +1 and 0 stands for −1, and a bit pair agrees when both bits are equal.
- R4: Output bit i is 1 exactly when neuron i counted more than N/2 agreements. A count of exactly N/2 gives 0.
- R5: `done` is a one-cycle pulse that is high in the cycle that begins N+2 clock edges after the start edge. `out_vec` takes its new value at that same edge, and `busy` is 0 while `done` is high.
- R6: `start` is ignored while `busy`. The address sequence and the result of the running evaluation are unchanged.
- R7: `out_vec` holds its value from one `done` pulse until the next.
- R8: Each start clears all neuron counters. Back-to-back runs with different inputs and base addresses each produce their own majority result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin evaluation (sampled only while idle) |
| in_vec | input | N | Binary input vector for the layer |
| w_base | input | AW | Address of the first weight word |
| w_rd_en | output | 1 | Weight RAM read enable |
| w_addr | output | AW | Weight RAM read address |
| w_data | input | N | Weight word, valid one cycle after the read |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_vec | output | N | Majority-vote layer output |

## Verification
The bench runs four kinds of input pattern, at N=16.

- **Graded agreements.** Neuron i agrees with exactly i inputs. This sweeps every count from 0 to 15 through the threshold in one run, so it separates a strict comparison from a non-strict one at the tie count of 8.
- **Uniform weights.** All-agree and all-disagree weight sets show that no counter overflows at the full count N and none underflows at zero.
- **Random runs.** Random weights, inputs and base addresses, including bases that wrap the address space, expose any rotation direction or alignment error. Such an error leaves uniform patterns intact but scrambles random ones.
- **Interference and restart.** A spurious start in the middle of a run shows that a busy engine ignores start. Back-to-back runs confirm that the counters clear and that the output holds between completions.

// File: rtl/bnn_layer_engine.sv
module bnn_layer_engine #(
  parameter int N  = 1024,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N-1:0]  in_vec,
  input  logic [AW-1:0] w_base,
  output logic          w_rd_en,
  output logic [AW-1:0] w_addr,
  input  logic [N-1:0]  w_data,
  output logic          busy,
  output logic          done,
  output logic [N-1:0]  out_vec
);

  localparam int SW   = $clog2(N);
  localparam int CW   = SW + 1;
  localparam int HALF = N / 2;

  logic [N-1:0]  in_reg;
  logic [SW-1:0] iss_cnt, acc_cnt;
  logic          vld, fin;
  logic [CW-1:0] cnt [N];

  wire go       = start && !busy;
  wire last_iss = w_rd_en && (iss_cnt == SW'(N - 1));
  wire last_acc = vld && (acc_cnt == SW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      w_rd_en <= 1'b0;
      w_addr  <= '0;
      iss_cnt <= '0;
      acc_cnt <= '0;
      vld     <= 1'b0;
      fin     <= 1'b0;
      in_reg  <= '0;
    end else begin
      done <= fin;
      fin  <= last_acc;
      vld  <= w_rd_en;
      if (go) begin
        busy    <= 1'b1;
        w_rd_en <= 1'b1;
        w_addr  <= w_base;
        iss_cnt <= '0;
        acc_cnt <= '0;
        in_reg  <= in_vec;
      end else begin
        if (fin) busy <= 1'b0;
        if (w_rd_en) begin
          if (last_iss) w_rd_en <= 1'b0;
          else begin
            w_addr  <= w_addr + AW'(1);
            iss_cnt <= iss_cnt + SW'(1);
          end
        end
        if (vld) begin
          in_reg  <= {in_reg[N-2:0], in_reg[N-1]};
          acc_cnt <= acc_cnt + SW'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_neuron
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt[g] <= '0;
      else if (go)  cnt[g] <= '0;
      else if (vld) cnt[g] <= cnt[g] + CW'(w_data[g] ~^ in_reg[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out_vec[g] <= 1'b0;
      else if (fin) out_vec[g] <= (cnt[g] > CW'(HALF));
    end
  end

  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> w_rd_en && w_addr == $past(w_base));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    w_rd_en && $past(w_rd_en) |-> w_addr == $past(w_addr) + AW'(1));
  a_r2_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    w_rd_en |-> busy);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !fin |=> busy);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(out_vec));

endmodule

// File: tb/sim_bnn_layer_engine.sv
module sim_bnn_layer_engine;
  localparam int N = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam time PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] in_vec = '0, w_data, out_vec;
  logic [AW-1:0] w_base = '0, w_addr;
  logic w_rd_en, busy, done;

  logic [N-1:0] mem [DEPTH];
  logic [N-1:0] wrow [N];
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  bnn_layer_engine #(.N(N), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec), .w_base(w_base),
    .w_rd_en(w_rd_en), .w_addr(w_addr), .w_data(w_data),
    .busy(busy), .done(done), .out_vec(out_vec));

  always_ff @(posedge clk) if (w_rd_en) w_data <= mem[w_addr];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_mem(input logic [AW-1:0] base);
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] w;
      for (int i = 0; i < N; i++) w[i] = wrow[i][(i - k + N) % N];
      mem[AW'(base + AW'(k))] = w;
    end
  endtask

  function automatic logic [N-1:0] ref_out(input logic [N-1:0] x);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int c = 0;
      for (int j = 0; j < N; j++) c += (wrow[i][j] == x[j]) ? 1 : 0;
      r[i] = (c > N / 2);
    end
    return r;
  endfunction

  task automatic run(input logic [N-1:0] x, input logic [AW-1:0] base, input bit poke, input string req);
    logic [N-1:0] exp;
    int cycles = 0, idx = 0;
    bit hung = 0;
    load_mem(base);
    exp = ref_out(x);
    @(negedge clk);
    in_vec = x; w_base = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (w_rd_en) begin
        chk(w_addr == AW'(base + AW'(idx)), "R2 address", 64'(w_addr), 64'(AW'(base + AW'(idx))));
        idx++;
      end
      if (poke && cycles == 3) begin
        start = 1'b1; in_vec = ~x; w_base = base + AW'(5);
      end else if (poke) start = 1'b0;
      @(posedge clk); @(negedge clk);
      cycles++;
      if (done) break;
      if (cycles > 4 * N + 20) begin hung = 1; break; end
    end
    start = 1'b0;
    chk(!hung, "R5 watchdog", 64'(cycles), 64'(N + 2));
    chk(cycles == N + 2, "R5 latency", 64'(cycles), 64'(N + 2));
    chk(idx == N, "R2 read count", 64'(idx), 64'(N));
    chk(!busy, "R5 idle at done", 64'(busy), 64'(0));
    chk(out_vec == exp, req, 64'(out_vec), 64'(exp));
    @(negedge clk);
    chk(!done, "R5 single pulse", 64'(done), 64'(0));
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] x, prev;
    void'($urandom(32'd2024));
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !w_rd_en, "R1 control idle", {busy, done, w_rd_en}, 0);
    chk(out_vec == '0, "R1 output zero", 64'(out_vec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !w_rd_en && out_vec == '0, "R1 after release", 64'(out_vec), 0);

    // R3 R4: neuron i agrees with exactly i inputs; bit 8 is the tie
    x = 16'hA5C3;
    for (int i = 0; i < N; i++) wrow[i] = x ^ ~N'((32'd1 << i) - 1);
    run(x, 6'd0, 0, "R4 graded counts");
    chk(out_vec[8] == 1'b0, "R4 tie gives 0", 64'(out_vec[8]), 0);
    chk(out_vec[9] == 1'b1, "R4 above half", 64'(out_vec[9]), 1);

    x = 16'h3C96;
    for (int i = 0; i < N; i++) wrow[i] = x;
    run(x, 6'd40, 0, "R4 all agree");
    chk(out_vec == '1, "R4 full count", 64'(out_vec), 64'(16'hFFFF));
    for (int i = 0; i < N; i++) wrow[i] = ~x;
    run(x, 6'd20, 0, "R8 all disagree after full");

    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < N; i++) wrow[i] = N'($urandom);
      x = N'($urandom);
      run(x, (t % 4 == 0) ? 6'd56 : AW'($urandom), 0, "R3 random layer");
    end

    for (int i = 0; i < N; i++) wrow[i] = N'($urandom);
    run(N'($urandom), 6'd60, 1, "R6 start while busy");

    prev = out_vec;
    repeat (10) @(negedge clk);
    chk(out_vec == prev && !busy, "R7 output holds", 64'(out_vec), 64'(prev));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule